// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a synchronous four-beat memory burst. A burst begins when either of two start strobes is high on a rising clock edge: one strobe comes from the processor side and one from the memory controller side. The strobe captures the full external address. After that, the block changes only the two least significant address bits, and it does so on each clock where the advance input is high. The upper bits stay as loaded until the next start.

Two stepping orders are available. Linear order counts the low bits upward and wraps inside the aligned four-word group. Interleaved order XORs the starting low bits with a running 2-bit beat count. A mode pin chooses between them. A build parameter can remove the pin's influence, and the block then behaves as it would with the pin left floating: the order is fixed to interleaved. The address is held in a register and appears on the output every clock. A new start may be issued on every clock with no gap between bursts.

Top module: `bas_gen`

## Requirements
- R1: While `rst` is high on a rising edge, `addr_o` becomes all zeros and `active_o` becomes 0 after that edge.
- R2: With `lin_order_i`=1 (linear), each accepted advance makes `addr_o[1:0]` equal to the previous value plus one, modulo 4. For example, a start at low bits 2 gives 2,3,0,1,2.
- R3: With `lin_order_i`=0 (interleaved), the low bits after the n-th advance equal the starting low bits XOR (n mod 4). For example, a start at 1 gives 1,0,3,2 and a start at 3 gives 3,2,1,0.
- R4: When no strobe is high and `adv_i` is 0, `addr_o` and `active_o` hold their values.
- R5: A high `pstrb_i` or a high `cstrb_i` on an edge loads `ext_addr_i` into `addr_o`, visible after that edge, and sets `active_o` to 1.
- R6: Starts on consecutive clocks each load their own address, with no idle cycle between them.
- R7: When a strobe and `adv_i` are both high on the same edge, the load takes effect and the advance is discarded.
- R8: During a burst, the bits of `addr_o` above bit 1 change only on a load or a reset.
- R9: While no burst is active (after reset and before any start), `adv_i` has no effect on `addr_o`.
- R10: With parameter `USE_MODE_PIN`=0, the order is interleaved whatever the value of `lin_order_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pstrb_i | input | 1 | Burst start strobe, processor side |
| cstrb_i | input | 1 | Burst start strobe, controller side |
| adv_i | input | 1 | Step to the next beat of the active burst |
| lin_order_i | input | 1 | 1 = linear order, 0 = interleaved order |
| ext_addr_i | input | AW | External start address |
| addr_o | output | AW | Registered current word address |
| active_o | output | 1 | A burst has been started since reset |

## Verification
Two functions can fall in the same edge: a start, on either strobe, and an advance of the running burst. The bench raises `adv_i` together with `pstrb_i` in the middle of a burst, and also together with `cstrb_i` on back-to-back starts. In each case it expects the freshly loaded address and a beat count that restarts from zero, so the next advance lands on the new address's first step and not on the next step of the old burst. A second instance is built with the mode pin disabled and runs the same stimulus, which shows that order stays interleaved while the pin asks for linear.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int LOW_W = 2;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } order_e;

  typedef logic [LOW_W-1:0] beat_t;
endpackage

// File: rtl/bas_start_capture.sv
module bas_start_capture
  import bas_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pstrb_i,
  input  logic          cstrb_i,
  input  logic [AW-1:0] ext_addr_i,
  output logic          load_o,
  output beat_t         base_lo_o
);
  beat_t base_q;

  assign load_o = pstrb_i | cstrb_i;

  always_ff @(posedge clk) begin
    if (rst)         base_q <= '0;
    else if (load_o) base_q <= ext_addr_i[LOW_W-1:0];
  end

  assign base_lo_o = base_q;

  a_r5_base_latched: assert property (@(posedge clk) disable iff (rst)
    load_o |=> base_q == $past(ext_addr_i[LOW_W-1:0]));
endmodule

// File: rtl/bas_step_calc.sv
module bas_step_calc
  import bas_pkg::*;
#(
  parameter bit USE_MODE_PIN = 1'b1
) (
  input  beat_t cur_lo_i,
  input  beat_t base_lo_i,
  input  beat_t cnt_i,
  input  logic  lin_order_i,
  output beat_t nxt_lo_o,
  output beat_t nxt_cnt_o
);
  order_e ord;

  assign nxt_cnt_o = beat_t'(cnt_i + beat_t'(1));

  generate
    if (USE_MODE_PIN) begin : g_pin
      assign ord = order_e'(lin_order_i);
    end else begin : g_fixed
      logic unused_pin;
      assign unused_pin = lin_order_i;
      assign ord = ORD_INTERLEAVE;
    end
  endgenerate

  always_comb begin
    if (ord == ORD_LINEAR) nxt_lo_o = beat_t'(cur_lo_i + beat_t'(1));
    else                   nxt_lo_o = base_lo_i ^ nxt_cnt_o;
  end
endmodule

// File: rtl/bas_gen.sv
module bas_gen
  import bas_pkg::*;
#(
  parameter int AW           = 18,
  parameter bit USE_MODE_PIN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pstrb_i,
  input  logic          cstrb_i,
  input  logic          adv_i,
  input  logic          lin_order_i,
  input  logic [AW-1:0] ext_addr_i,
  output logic [AW-1:0] addr_o,
  output logic          active_o
);
  localparam int HI_W = AW - LOW_W;

  logic          load;
  beat_t         base_lo, cnt_q, nxt_lo, nxt_cnt;
  logic [AW-1:0] addr_q;
  logic          active_q;
  logic          step;

  bas_start_capture #(.AW(AW)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .pstrb_i    (pstrb_i),
    .cstrb_i    (cstrb_i),
    .ext_addr_i (ext_addr_i),
    .load_o     (load),
    .base_lo_o  (base_lo)
  );

  bas_step_calc #(.USE_MODE_PIN(USE_MODE_PIN)) u_step (
    .cur_lo_i    (addr_q[LOW_W-1:0]),
    .base_lo_i   (base_lo),
    .cnt_i       (cnt_q),
    .lin_order_i (lin_order_i),
    .nxt_lo_o    (nxt_lo),
    .nxt_cnt_o   (nxt_cnt)
  );

  assign step = adv_i & active_q & ~load;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      addr_q   <= ext_addr_i;
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (step) begin
      addr_q[LOW_W-1:0] <= nxt_lo;
      cnt_q             <= nxt_cnt;
    end
  end

  assign addr_o   = addr_q;
  assign active_o = active_q;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && !active_o));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!pstrb_i && !cstrb_i && !adv_i) |=> ($stable(addr_o) && $stable(active_o)));

  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    (pstrb_i || cstrb_i) |=> (addr_o == $past(ext_addr_i) && active_o));

  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (!pstrb_i && !cstrb_i) |=> $stable(addr_o[AW-1:LOW_W]));

  a_r9_idle_adv: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !pstrb_i && !cstrb_i) |=> $stable(addr_o));

  generate
    if (USE_MODE_PIN) begin : g_lin_chk
      a_r2_linear_step: assert property (@(posedge clk) disable iff (rst)
        (active_o && adv_i && lin_order_i && !pstrb_i && !cstrb_i)
        |=> addr_o[LOW_W-1:0] == beat_t'($past(addr_o[LOW_W-1:0]) + beat_t'(1)));
    end
  endgenerate

  initial begin
    a_aw_wide: assert (HI_W >= 1);
  end
endmodule

// File: tb/test_bas_gen.sv
module test_bas_gen;
  localparam int AW = 18;

  typedef struct {
    logic [AW-1:0] a_addr;
    logic          a_act;
    logic [AW-1:0] b_addr;
    logic          b_act;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pstrb = 1'b0, cstrb = 1'b0, adv = 1'b0, lin = 1'b0;
  logic [AW-1:0] ext = '0;
  logic [AW-1:0] addr_a, addr_b;
  logic act_a, act_b;

  int n_tests = 0;
  int n_fail  = 0;
  exp_t q[$];

  // model state: A follows mode pin, B is fixed interleaved
  logic [AW-1:0] ma_addr = '0, mb_addr = '0;
  logic [1:0]    ma_base = '0, mb_base = '0, ma_cnt = '0, mb_cnt = '0;
  logic          ma_act = 1'b0, mb_act = 1'b0;

  always #10 clk = ~clk;

  bas_gen #(.AW(AW), .USE_MODE_PIN(1'b1)) i_bas_gen (
    .clk(clk), .rst(rst), .pstrb_i(pstrb), .cstrb_i(cstrb), .adv_i(adv),
    .lin_order_i(lin), .ext_addr_i(ext), .addr_o(addr_a), .active_o(act_a));

  bas_gen #(.AW(AW), .USE_MODE_PIN(1'b0)) i_bas_gen_fixed (
    .clk(clk), .rst(rst), .pstrb_i(pstrb), .cstrb_i(cstrb), .adv_i(adv),
    .lin_order_i(lin), .ext_addr_i(ext), .addr_o(addr_b), .active_o(act_b));

  task automatic step(input logic r, input logic p, input logic c, input logic a,
                      input logic l, input logic [AW-1:0] e, input string tag);
    exp_t x;
    @(negedge clk);
    rst = r; pstrb = p; cstrb = c; adv = a; lin = l; ext = e;
    if (r) begin
      ma_addr = '0; ma_cnt = '0; ma_act = 1'b0; ma_base = '0;
      mb_addr = '0; mb_cnt = '0; mb_act = 1'b0; mb_base = '0;
    end else if (p || c) begin
      ma_addr = e; ma_base = e[1:0]; ma_cnt = '0; ma_act = 1'b1;
      mb_addr = e; mb_base = e[1:0]; mb_cnt = '0; mb_act = 1'b1;
    end else if (a) begin
      if (ma_act) begin
        ma_cnt = ma_cnt + 2'd1;
        ma_addr[1:0] = l ? ma_addr[1:0] + 2'd1 : ma_base ^ ma_cnt;
      end
      if (mb_act) begin
        mb_cnt = mb_cnt + 2'd1;
        mb_addr[1:0] = mb_base ^ mb_cnt;
      end
    end
    x.a_addr = ma_addr; x.a_act = ma_act;
    x.b_addr = mb_addr; x.b_act = mb_act;
    x.tag = tag;
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_tests++;
      if (addr_a !== x.a_addr || act_a !== x.a_act) begin
        n_fail++;
        $display("FAIL %s pin-mode: addr=%h act=%b expected addr=%h act=%b",
                 x.tag, addr_a, act_a, x.a_addr, x.a_act);
      end
      n_tests++;
      if (addr_b !== x.b_addr || act_b !== x.b_act) begin
        n_fail++;
        $display("FAIL %s fixed-mode: addr=%h act=%b expected addr=%h act=%b",
                 x.tag, addr_b, act_b, x.b_addr, x.b_act);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 5000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<5000", wd);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(1, 0, 0, 0, 0, '0, "R1");
    step(1, 0, 0, 1, 1, 18'h3ffff, "R1");
    // R9 advance before any start has no effect
    step(0, 0, 0, 1, 1, '0, "R9");
    step(0, 0, 0, 1, 0, '0, "R9");
    // R2 linear from low bits 2
    step(0, 1, 0, 0, 1, 18'h12346, "R5");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, '0, "R2");
    // R4 hold
    step(0, 0, 0, 0, 1, 18'h00001, "R4");
    step(0, 0, 0, 0, 0, 18'h3ffff, "R4");
    // R3 interleaved from each start value, via controller strobe
    for (int s = 0; s < 4; s++) begin
      step(0, 0, 1, 0, 0, 18'h2ab00 | 18'(s), "R5");
      for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, '0, "R3");
    end
    // R10 pin asks linear; fixed instance stays interleaved
    step(0, 1, 0, 0, 1, 18'h0f0f1, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, '0, "R10");
    // R7 load together with advance mid-burst
    step(0, 1, 0, 1, 0, 18'h15557, "R7");
    step(0, 0, 0, 1, 0, '0, "R7");
    // R6 back-to-back starts, alternating strobes, some with advance
    step(0, 1, 0, 0, 0, 18'h00003, "R6");
    step(0, 0, 1, 1, 0, 18'h3fffe, "R6");
    step(0, 1, 1, 0, 1, 18'h20001, "R6");
    step(0, 0, 1, 1, 1, 18'h1aaa2, "R6");
    // R8 upper bits across long advance run
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, i[0], '0, "R8");
    // reset mid-burst
    step(1, 0, 0, 1, 1, 18'h11111, "R1");
    step(0, 0, 0, 1, 1, '0, "R9");
    repeat (3) @(posedge clk);
    #5;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule